// File: doc/BRIEF.md
# Busy-Status Read Overlay for a Flash Controller

While a self-timed program or erase of a flash array is running, the array contents cannot be trusted. This block sits on the read path and, for the duration of that busy interval, replaces two bits of the returned word with completion indicators. Software polls the word and learns from them when the operation has ended. Outside the busy interval the block passes array data through untouched.

The first indicator is a polarity bit. Its value depends on the operation. For a word program it is the inverse of the corresponding bit of the word being written. For any erase it is forced to zero. When the operation completes, the bit shows the true stored value, so software sees it flip to the expected polarity.

The second indicator is a toggle bit. It changes state once for each separate read access, not once per clock, so two back-to-back reads always differ while busy. The busy flag, the operation type and the loaded word come from the sequencer. The read strobe and the array word come from the host bus side. The output is a combinational function of the inputs and one toggle flop, so a read sees its data in the same cycle.

Top module: `pollReadMux`

## Requirements
- R1: While `busy` is 0, `readData` equals `arrayData` on every bit.
- R2: While `busy` is 1 and `opIsErase` is 0 (word program), `readData[7]` equals the inverse of `loadedWord[7]`.
- R3: While `busy` is 1 and `opIsErase` is 1 (chip or sector erase), `readData[7]` is 0 regardless of `loadedWord`.
- R4: While `busy` is 1, `readData[6]` shows the toggle flop. A read access is a clock edge at which `readStrobe` is sampled 1 after having been sampled 0 at the previous edge. Each read access inverts the flop at that edge. Holding `readStrobe` at 1 for more edges does not invert it again.
- R5: The toggle flop is 0 after reset, and it is forced to 0 at every clock edge that samples `busy` as 0. As a result, the first read access of a busy interval makes `readData[6]` read 1.
- R6: While `busy` is 1, every bit of `readData` other than 7 and 6 equals the same bit of `arrayData`.
- R7: While `busy` is 1 and no read access occurs, `readData[6]` keeps its value from edge to edge, so polling may begin at any point of the interval.
- R8: A rising `readStrobe` sampled at the same edge as `busy` = 0 does not change the toggle flop. The flop stays 0 (see R5).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busy | input | 1 | Embedded program or erase in progress |
| opIsErase | input | 1 | 1 = erase operation, 0 = word program |
| loadedWord | input | 16 | Word being programmed |
| readStrobe | input | 1 | Host read access strobe, level |
| arrayData | input | 16 | Data read from the array |
| readData | output | 16 | Word returned to the host |

## Verification
Two events can land on one clock edge. The first is the toggle advance caused by a new read access. The second is the forced clear that comes with the end of the busy interval, or the start of a new one. The bench drives a strobe rise in exactly the cycle where `busy` drops, and again in the cycle where it rises. A cycle-by-cycle reference model of the toggle flop, written from R4, R5 and R8, predicts which effect wins. The scoreboard then compares the full word one edge later, in particular bit 6 on the first read of the following interval.

// File: rtl/pollPkg.sv
package pollPkg;
  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic advance;   // invert the toggle flop at this edge
    logic clear;     // force the toggle flop to zero at this edge
  } pollStrobeT;
endpackage

// File: rtl/pollCtrl.sv
module pollCtrl
  import pollPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busy,
  input  logic       readStrobe,
  output pollStrobeT strobes
);
  logic strobePrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobePrev <= 1'b0;
    else       strobePrev <= readStrobe;
  end

  always_comb begin
    strobes.clear   = ~busy;
    strobes.advance = busy & readStrobe & ~strobePrev;
  end

  // R4: a held strobe yields one advance only
  a_r4_single_advance: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |=> !strobes.advance);

  // R8: no advance while the operation is idle
  a_r8_idle_no_advance: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clear && readStrobe) |-> !strobes.advance);
endmodule

// File: rtl/pollDatapath.sv
module pollDatapath
  import pollPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  logic              opIsErase,
  input  logic [DATA_W-1:0] loadedWord,
  input  logic [DATA_W-1:0] arrayData,
  input  pollStrobeT        strobes,
  output logic [DATA_W-1:0] readData
);
  logic togState;
  logic pollValue;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                togState <= 1'b0;
    else if (strobes.clear)   togState <= 1'b0;
    else if (strobes.advance) togState <= ~togState;
  end

  assign pollValue = opIsErase ? 1'b0 : ~loadedWord[POLL_BIT];

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == POLL_BIT) begin : g_poll
      assign readData[i] = busy ? pollValue : arrayData[i];
    end else if (i == TOG_BIT) begin : g_tog
      assign readData[i] = busy ? togState : arrayData[i];
    end else begin : g_pass
      assign readData[i] = arrayData[i];
    end
  end

  // R5: idle edge leaves the toggle cleared
  a_r5_clear_idle: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (togState == 1'b0));

  // R4: every advance flips the toggle
  a_r4_flip: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && !strobes.clear) |=> (togState != $past(togState)));

  // R7: no read access, no change while busy
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.advance && !strobes.clear) |=> $stable(togState));

  // R3: erase polls as zero
  a_r3_erase_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busy && opIsErase) |-> (readData[POLL_BIT] == 1'b0));

  // R2: program polls as inverted loaded bit
  a_r2_prog_invert: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !opIsErase) |-> (readData[POLL_BIT] != loadedWord[POLL_BIT]));

  // R1: idle reads pass the array
  a_r1_idle_pass: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (readData == arrayData));
endmodule

// File: rtl/pollReadMux.sv
module pollReadMux
  import pollPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  logic              opIsErase,
  input  logic [DATA_W-1:0] loadedWord,
  input  logic              readStrobe,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] readData
);
  pollStrobeT strobes;

  pollCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busy       (busy),
    .readStrobe (readStrobe),
    .strobes    (strobes)
  );

  pollDatapath #(
    .DATA_W   (DATA_W),
    .POLL_BIT (POLL_BIT),
    .TOG_BIT  (TOG_BIT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .busy       (busy),
    .opIsErase  (opIsErase),
    .loadedWord (loadedWord),
    .arrayData  (arrayData),
    .strobes    (strobes),
    .readData   (readData)
  );
endmodule

// File: tb/pollReadMux_bench.sv
module pollReadMux_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busy = 1'b0;
  logic        opIsErase = 1'b0;
  logic [15:0] loadedWord = '0;
  logic        readStrobe = 1'b0;
  logic [15:0] arrayData = '0;
  logic [15:0] readData;

  int total = 0;
  int bad = 0;
  int cycleCnt = 0;
  bit finished = 0;

  typedef struct {
    int          due;
    logic [15:0] exp;
    string       tag;
  } itemT;
  itemT expQ[$];

  // reference model state
  logic mTog = 1'b0;
  logic mPrev = 1'b0;

  pollReadMux u_pollReadMux (
    .clk(clk), .rstN(rstN), .busy(busy), .opIsErase(opIsErase),
    .loadedWord(loadedWord), .readStrobe(readStrobe),
    .arrayData(arrayData), .readData(readData)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  // Monitor: compare due items away from the active edge
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].due <= cycleCnt) begin
      itemT it;
      it = expQ.pop_front();
      total++;
      if (readData !== it.exp) begin
        bad++;
        $display("FAIL %s: got %h expected %h", it.tag, readData, it.exp);
      end
    end
  end

  function automatic logic [15:0] model(logic b, logic er, logic [15:0] ld,
                                        logic [15:0] arr, logic tg);
    logic [15:0] w;
    w = arr;
    if (b) begin
      w[7] = er ? 1'b0 : ~ld[7];
      w[6] = tg;
    end
    return w;
  endfunction

  // Driver: one cycle of stimulus, expectation checked after the next edge
  task automatic tick(input logic b, input logic er, input logic st,
                      input logic [15:0] ld, input logic [15:0] arr,
                      input string tag);
    itemT it;
    @(negedge clk);
    #1;
    busy = b; opIsErase = er; readStrobe = st; loadedWord = ld; arrayData = arr;
    if (!b) mTog = 1'b0;
    else if (st && !mPrev) mTog = ~mTog;
    mPrev = st;
    it.due = cycleCnt + 1;
    it.exp = model(b, er, ld, arr, mTog);
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // One read access: strobe high for hold cycles, then low one cycle
  task automatic readAcc(input logic b, input logic er, input logic [15:0] ld,
                         input int hold, input string tag);
    for (int k = 0; k < hold; k++) tick(b, er, 1'b1, ld, 16'($urandom), tag);
    tick(b, er, 1'b0, ld, 16'($urandom), tag);
  endtask

  initial begin
    // R5: reset state, idle output follows the array
    #5;
    arrayData = 16'hA5C3;
    #1;
    total++;
    if (readData !== 16'hA5C3) begin
      bad++;
      $display("FAIL R5/R1 reset: got %h expected %h", readData, 16'hA5C3);
    end
    repeat (2) @(negedge clk);
    rstN = 1'b1;

    // R1 and R8: idle reads pass data, strobe edges do not count
    readAcc(1'b0, 1'b0, 16'h00FF, 1, "R1 idle read");
    readAcc(1'b0, 1'b1, 16'hFFFF, 2, "R8 idle strobe");
    tick(1'b0, 1'b0, 1'b0, 16'h0000, 16'hFFFF, "R1 idle all ones");

    // R2, R4, R6: program with loaded bit7 = 1, toggle 1,0,1,0
    for (int n = 0; n < 4; n++) readAcc(1'b1, 1'b0, 16'h1280, 1, "R2/R4/R6 program poll");
    // R4: long held strobe counts once
    readAcc(1'b1, 1'b0, 16'h1280, 4, "R4 held strobe");
    // R7: no reads, bit 6 steady
    for (int n = 0; n < 5; n++) tick(1'b1, 1'b0, 1'b0, 16'h1280, 16'($urandom), "R7 hold no read");
    readAcc(1'b1, 1'b0, 16'h1280, 1, "R4 late poll");

    // R1: completion returns true data
    tick(1'b0, 1'b0, 1'b0, 16'h1280, 16'h5A5A, "R1 after done");

    // R3, R5: erase, loaded bit7 = 0 so only erase rule gives 0
    for (int n = 0; n < 3; n++) readAcc(1'b1, 1'b1, 16'h0000, 1, "R3/R5 erase poll");
    // Coincidence: strobe rises in the edge where busy drops (R8, R5)
    tick(1'b0, 1'b1, 1'b1, 16'h0000, 16'h1234, "R8 strobe at busy fall");
    tick(1'b0, 1'b1, 1'b0, 16'h0000, 16'h4321, "R1 idle after fall");

    // R2: program with loaded bit7 = 0 gives 1; strobe rises with busy
    tick(1'b1, 1'b0, 1'b1, 16'h007F, 16'($urandom), "R5 first read with busy rise");
    tick(1'b1, 1'b0, 1'b0, 16'h007F, 16'($urandom), "R2 poll inverted zero");
    readAcc(1'b1, 1'b0, 16'h007F, 1, "R4 second read");
    // R6: all-ones and all-zeros array under busy
    tick(1'b1, 1'b0, 1'b0, 16'h007F, 16'hFFFF, "R6 pass ones");
    tick(1'b1, 1'b0, 1'b0, 16'h007F, 16'h0000, "R6 pass zeros");
    tick(1'b0, 1'b0, 1'b0, 16'h007F, 16'hBEEF, "R1 final idle");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule